// File: doc/BRIEF.md
# Cache-Control Address-Space Access Guard

This block screens alternate-space loads and stores that have already been steered to the cache-control address spaces. For each request it decides whether the access is legal. If it is not, it reports exactly one fault kind together with a fault-type code and the faulting operand address. The address is reported exactly as it arrived, because these accesses bypass address translation.

A legal supervisor store to the flush address space starts a walk over every level-1 instruction-cache set. The walk clears one set's valid bits per clock. While the walk runs, the block refuses new requests, so accesses stay strictly ordered and none is started ahead of time. A legal load completes with all-zero data, since every data bit of these spaces is don't-care.

The cache arrays, address translation and trap delivery live elsewhere. The block only drives the clear strobe and the set index toward the tag array.

Top module: `cc_asi_guard`

## Requirements
- R1: Only opcode classes 0 to 5 are accepted. The encodings are 0 pair load, 1 extended load, 2 floating doubleword load, 3 pair store, 4 extended store and 5 floating doubleword store. Classes 6 and 7 yield `flt_kind` 1 (invalid space) with `flt_ftype` 0x08.
- R2: A load class (0 to 2) aimed at the flush space (`FLUSH_ASI`, default 0x67) is reported as `flt_kind` 1 with `flt_ftype` 0x08.
- R3: An access made with `req_priv` low yields `flt_kind` 2 (privilege). A user-mode store to the flush space starts no walk.
- R4: An operand address with any of bits 2..0 set yields `flt_kind` 3 (misaligned).
- R5: Only one fault kind is reported per request. The invalid-space fault wins over the privilege fault, which wins over misalignment. `flt_ftype` is 0x00 for every kind other than 1.
- R6: Each accepted request produces a one-cycle `resp_valid` pulse on the cycle after acceptance. On a fault, `flt_addr` equals the untranslated `req_va`. Otherwise it is zero.
- R7: A fault-free load raises `rd_valid` together with `resp_valid`, and `rd_data` is all zeros.
- R8: A fault-free supervisor store of class 3 to 5 to the flush space raises `busy` and `inv_en` from the next cycle for exactly `SETS` cycles. Over those cycles `inv_idx` steps from 0 to `SETS`-1, one step per cycle. Any address (when aligned) and any data start the walk.
- R9: While `busy` is high, `req_ready` is low and a request produces no response.
- R10: After reset, `busy`, `inv_en`, `resp_valid`, `rd_valid` and `flt_kind` are zero, and `req_ready` is one.
- R11: A fault-free store to a space other than the flush space responds with `flt_kind` 0, no read data and no walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Decoded opcode class |
| req_asi | input | 8 | Address space identifier |
| req_va | input | VA_W | Operand address, untranslated |
| req_priv | input | 1 | High in supervisor mode |
| req_ready | output | 1 | Request can be taken this cycle |
| resp_valid | output | 1 | Completion pulse for an accepted request |
| flt_kind | output | 2 | 0 none, 1 invalid space, 2 privilege, 3 misaligned |
| flt_ftype | output | 8 | Fault-type code |
| flt_addr | output | VA_W | Faulting operand address |
| rd_valid | output | 1 | Load data valid |
| rd_data | output | DATA_W | Load data |
| busy | output | 1 | Invalidation walk in progress |
| inv_en | output | 1 | Clear valid bits at `inv_idx` |
| inv_idx | output | clog2(SETS) | Set index being cleared |

## Verification
The properties assume that `req_op`, `req_asi`, `req_va` and `req_priv` are stable and known whenever `req_valid` is high. They also assume that a request raised during a walk is meant to be dropped, not held. The bench drives every request on the falling edge and holds it for one full cycle. It reads `req_ready` before deciding whether a response is due. It deliberately raises one request in the middle of a walk to exercise the drop rule.

// File: rtl/cc_asi_guard.sv
module cc_asi_guard #(
  parameter int          SETS      = 64,
  parameter int          VA_W      = 64,
  parameter int          DATA_W    = 64,
  parameter logic [7:0]  FLUSH_ASI = 8'h67
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_op,
  input  logic [7:0]               req_asi,
  input  logic [VA_W-1:0]          req_va,
  input  logic                     req_priv,
  output logic                     req_ready,
  output logic                     resp_valid,
  output logic [1:0]               flt_kind,
  output logic [7:0]               flt_ftype,
  output logic [VA_W-1:0]          flt_addr,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     busy,
  output logic                     inv_en,
  output logic [$clog2(SETS)-1:0]  inv_idx
);

  localparam int IDX_W = $clog2(SETS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);
  localparam logic [7:0] FT_BAD_SPACE = 8'h08;

  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_BAD  = 2'd1;
  localparam logic [1:0] K_PRIV = 2'd2;
  localparam logic [1:0] K_ALGN = 2'd3;

  logic       take, op_ok, is_st, hit_flush, bad_space, start;
  logic [1:0] kind_n;

  assign req_ready = ~busy;
  assign take      = req_valid & ~busy;
  assign op_ok     = req_op <= 3'd5;
  assign is_st     = op_ok & (req_op >= 3'd3);
  assign hit_flush = req_asi == FLUSH_ASI;
  assign bad_space = ~op_ok | (hit_flush & ~is_st);

  always_comb begin
    if (bad_space)              kind_n = K_BAD;
    else if (!req_priv)         kind_n = K_PRIV;
    else if (req_va[2:0] != '0) kind_n = K_ALGN;
    else                        kind_n = K_NONE;
  end

  assign start   = take & (kind_n == K_NONE) & is_st & hit_flush;
  assign inv_en  = busy;
  assign rd_data = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      flt_kind   <= K_NONE;
      flt_ftype  <= '0;
      flt_addr   <= '0;
      rd_valid   <= 1'b0;
    end else begin
      resp_valid <= take;
      flt_kind   <= take ? kind_n : K_NONE;
      flt_ftype  <= (take && kind_n == K_BAD) ? FT_BAD_SPACE : 8'h00;
      flt_addr   <= (take && kind_n != K_NONE) ? req_va : '0;
      rd_valid   <= take & (kind_n == K_NONE) & ~is_st;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      inv_idx <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      inv_idx <= '0;
    end else if (busy) begin
      if (inv_idx == LAST) busy <= 1'b0;
      else                 inv_idx <= inv_idx + 1'b1;
    end
  end

endmodule

// File: rtl/cc_asi_guard_chk.sv
module cc_asi_guard_chk #(
  parameter int          SETS      = 64,
  parameter int          VA_W      = 64,
  parameter logic [7:0]  FLUSH_ASI = 8'h67
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [2:0]               req_op,
  input logic [7:0]               req_asi,
  input logic [VA_W-1:0]          req_va,
  input logic                     req_priv,
  input logic                     resp_valid,
  input logic [1:0]               flt_kind,
  input logic [7:0]               flt_ftype,
  input logic                     rd_valid,
  input logic                     busy,
  input logic [$clog2(SETS)-1:0]  inv_idx
);
  localparam int IDX_W = $clog2(SETS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SETS - 1);

  p_busy_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> !resp_valid);

  p_walk_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && inv_idx != LAST) |=> (busy && inv_idx == $past(inv_idx) + 1'b1));

  p_walk_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && inv_idx == LAST && !$past(!rst_n)) |=> !busy);

  p_walk_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_priv && req_asi == FLUSH_ASI && req_op >= 3'd3
     && req_op <= 3'd5 && req_va[2:0] == 3'd0) |=> (busy && inv_idx == '0));

  p_user_no_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !req_priv) |=> !busy);

  p_ftype_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ((flt_kind == 2'd1) == (flt_ftype == 8'h08)));

  p_fault_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && flt_kind != 2'd0) |-> !rd_valid);

  p_resp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || flt_kind != 2'd0) |-> resp_valid);
endmodule

bind cc_asi_guard cc_asi_guard_chk #(.SETS(SETS), .VA_W(VA_W), .FLUSH_ASI(FLUSH_ASI)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_asi(req_asi), .req_va(req_va), .req_priv(req_priv),
  .resp_valid(resp_valid), .flt_kind(flt_kind), .flt_ftype(flt_ftype),
  .rd_valid(rd_valid), .busy(busy), .inv_idx(inv_idx));

// File: tb/tb_cc_asi_guard.sv
module tb_cc_asi_guard;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 64;
  localparam int IW = $clog2(SETS);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_priv = 0;
  logic [2:0] req_op = 0;
  logic [7:0] req_asi = 0;
  logic [63:0] req_va = 0;
  logic req_ready, resp_valid, rd_valid, busy, inv_en;
  logic [1:0] flt_kind;
  logic [7:0] flt_ftype;
  logic [63:0] flt_addr, rd_data;
  logic [IW-1:0] inv_idx;

  int n_checks = 0, n_fail = 0;

  typedef struct {
    logic [1:0]  kind;
    logic [7:0]  ft;
    logic [63:0] addr;
    logic        rd;
    int          tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_asi_guard #(.SETS(SETS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_asi(req_asi), .req_va(req_va), .req_priv(req_priv),
    .req_ready(req_ready), .resp_valid(resp_valid), .flt_kind(flt_kind),
    .flt_ftype(flt_ftype), .flt_addr(flt_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .inv_en(inv_en), .inv_idx(inv_idx));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] op, input logic [7:0] asi,
                                 input logic [63:0] va, input bit priv, input int tag);
    exp_t e;
    e.tag = tag; e.ft = 8'h00; e.rd = 1'b0;
    if (op > 3'd5 || (asi == 8'h67 && op < 3'd3)) begin e.kind = 2'd1; e.ft = 8'h08; end
    else if (!priv)           e.kind = 2'd2;
    else if (va[2:0] != 3'd0) e.kind = 2'd3;
    else begin e.kind = 2'd0; e.rd = (op < 3'd3); end
    e.addr = (e.kind != 2'd0) ? va : 64'd0;
    return e;
  endfunction

  task automatic issue(input logic [2:0] op, input logic [7:0] asi,
                       input logic [63:0] va, input bit priv, input int tag);
    @(negedge clk);
    req_valid = 1; req_op = op; req_asi = asi; req_va = va; req_priv = priv;
    if (req_ready) sb.push_back(model(op, asi, va, priv, tag));
    @(negedge clk);
    req_valid = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb.size() == 0) chk(0, "R9 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(flt_kind == e.kind, $sformatf("R%0d kind", e.tag), flt_kind, e.kind);
        chk(flt_ftype == e.ft, $sformatf("R%0d ftype", e.tag), flt_ftype, e.ft);
        chk(flt_addr == e.addr, $sformatf("R6 addr (R%0d)", e.tag), flt_addr, e.addr);
        chk(rd_valid == e.rd, $sformatf("R7 rd_valid (R%0d)", e.tag), rd_valid, e.rd);
        if (e.rd) chk(rd_data == 64'd0, "R7 zero data", rd_data, 0);
      end
    end else if (rst_n && rd_valid) chk(0, "R6 rd_valid without resp", 1, 0);
  end

  task automatic walk_check(input bool_probe);
    for (int k = 0; k < SETS; k++) begin
      chk(busy && inv_en && inv_idx == IW'(k), "R8 walk index", {busy, inv_en, 6'd0, 56'(inv_idx)}, k);
      if (bool_probe && k == 10) begin
        req_valid = 1; req_op = 3'd0; req_asi = 8'h10; req_va = 64'h40; req_priv = 1;
        chk(req_ready == 0, "R9 ready low while busy", req_ready, 0);
      end
      if (k == 11) req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    chk(!busy && !inv_en && req_ready, "R8 walk ends after SETS cycles", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !inv_en && !resp_valid && !rd_valid && flt_kind == 0 && req_ready,
        "R10 reset state", {busy, inv_en, resp_valid, rd_valid}, 0);

    issue(3'd0, 8'h10, 64'h1000, 1, 7);               // R7 pair load
    issue(3'd1, 8'h11, 64'h0, 1, 7);                  // R7 extended load
    issue(3'd2, 8'h12, 64'hFFFF_FFF8, 1, 7);          // R7 fp load
    issue(3'd3, 8'h20, 64'h80, 1, 11);                // R11 non-flush store
    chk(!busy, "R11 no walk", busy, 0);
    issue(3'd6, 8'h20, 64'h1234_5678_0000_0010, 1, 1); // R1 class 6
    issue(3'd7, 8'h67, 64'h8, 1, 1);                  // R1 class 7
    issue(3'd1, 8'h67, 64'h100, 1, 2);                // R2 load of flush space
    issue(3'd4, 8'h67, 64'h100, 0, 3);                // R3 user flush store
    chk(!busy, "R3 user flush starts no walk", busy, 0);
    issue(3'd0, 8'h30, 64'h200, 0, 3);                // R3 user load
    issue(3'd1, 8'h30, 64'h204, 1, 4);                // R4 bit 2
    issue(3'd5, 8'h30, 64'h7, 1, 4);                  // R4 bits 0..2
    issue(3'd7, 8'h30, 64'h3, 0, 5);                  // R5 invalid beats priv+misalign
    issue(3'd3, 8'h30, 64'h1, 0, 5);                  // R5 priv beats misalign
    issue(3'd2, 8'h67, 64'h5, 0, 5);                  // R5 flush load: invalid first

    issue(3'd5, 8'h67, 64'hDEAD_BEEF_0000_0008, 1, 8); // R8 flush walk
    walk_check(1);                                     // R9 probe mid-walk
    issue(3'd3, 8'h67, 64'h0, 1, 8);                  // R8 second flush, other class
    walk_check(0);
    issue(3'd0, 8'h10, 64'h18, 1, 7);                 // R7 after walk

    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R6 every accepted request answered", sb.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule